// File: doc/BRIEF.md
# Sequential Signed Shift-Add Multiplier

This block multiplies two W-bit two's-complement numbers and returns their full 2W-bit signed product. It trades speed for area. There is one 2W-bit adder and one accumulator register. One multiplier bit is consumed per clock, starting from the least significant bit. Each step adds a sign-extended, left-shifted copy of the multiplicand to a running partial product, or adds nothing.

Signed multipliers are handled directly. The multiplier's top bit carries a negative weight, so in the final step the shifted multiplicand is subtracted rather than added. There is no operand recoding and no correction of the sign afterwards.

A one-cycle `start_i` while idle captures both operands. The unit then stays busy for exactly W cycles and raises `done_o` for one cycle, when the result is complete. The result stays on `product_o` until the next accepted start.

Top module: `seq_signed_mul`

## Requirements
- R1: While reset is asserted and right after it, `busy_o` and `done_o` are 0 and `product_o` is all zeros.
- R2: When `start_i` is 1 at a rising edge while `busy_o` is 0, both operands are captured at that edge and `busy_o` is 1 in the following cycle. Later changes of the operand inputs do not alter the result.
- R3: `done_o` rises exactly W rising edges after the accepting edge, and `busy_o` falls at that same edge.
- R4: In the cycle where `done_o` is 1, `product_o` equals the signed product of the captured operands. It is written as a 2W-bit two's-complement value, for every combination of operand signs.
- R5: When the multiplier's top bit is 1, the last step subtracts the multiplicand shifted left by W-1. For example, with W=8, (-6)x(-5) gives 16'h001E and 7x(-3) gives 16'hFFEB.
- R6: A zero multiplicand or a zero multiplier gives a product of all zeros.
- R7: The most negative value times itself gives +2^(2W-2), which is 16'h4000 for W=8.
- R8: `start_i` asserted while `busy_o` is 1 is ignored. The running operation keeps its operands and its timing.
- R9: While idle and not accepting a start, `product_o` holds its value, including after `done_o` falls.
- R10: `done_o` is high for exactly one cycle per operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to begin a multiplication |
| mcand_i | input | W | Multiplicand, two's complement |
| mplier_i | input | W | Multiplier, two's complement |
| busy_o | output | 1 | High while iteration steps are running |
| done_o | output | 1 | One-cycle pulse when the product is complete |
| product_o | output | 2W | Signed product, valid from `done_o` until the next start |

## Verification
Directed pairs cover positive times negative, negative times negative, and positive times positive. These separate a correct subtraction on the final step from a plain unsigned sum, and from a missing sign extension of the shifted multiplicand. Zero operands, minus one squared, and the most negative value squared probe the extremes of the adder width. The most negative value squared is the one case where a truncated or sign-blind final step gives the wrong sign. Random operand pairs are compared against integer multiplication. The operand inputs are scrambled after acceptance, and a second start is injected mid-run, so that operand capture and start rejection are seen at the outputs.

// File: rtl/smul_pkg.sv
package smul_pkg;

  // Per-cycle control word from the sequencer to the datapath.
  typedef struct packed {
    logic load;   // capture operands, clear accumulator
    logic step;   // perform one accumulate step
    logic sel;    // current multiplier bit
    logic last;   // step on the multiplier sign bit
  } smul_ctl_t;

endpackage

// File: rtl/smul_ctrl.sv
module smul_ctrl
  import smul_pkg::*;
#(
  parameter int W  = 8,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [W-1:0]  mplier_i,
  output smul_ctl_t     ctl_o,
  output logic [IW-1:0] idx_o,
  output logic          busy_o,
  output logic          done_o
);

  logic          busy_q, busy_d;
  logic          done_q, done_d;
  logic [IW-1:0] cnt_q, cnt_d;
  logic [W-1:0]  mpl_q, mpl_d;
  logic          last_step;
  logic          adv_en;
  smul_ctl_t     ctl;

  assign last_step = (cnt_q == IW'(W - 1));

  always_comb begin
    busy_d = busy_q;
    done_d = 1'b0;
    cnt_d  = cnt_q;
    mpl_d  = mpl_q;
    ctl    = '0;
    if (busy_q) begin
      ctl.step = 1'b1;
      ctl.sel  = mpl_q[0];
      ctl.last = last_step;
      mpl_d    = mpl_q >> 1;
      cnt_d    = cnt_q + 1'b1;
      if (last_step) begin
        busy_d = 1'b0;
        done_d = 1'b1;
        cnt_d  = '0;
      end
    end else if (start_i) begin
      ctl.load = 1'b1;
      busy_d   = 1'b1;
      cnt_d    = '0;
      mpl_d    = mplier_i;
    end
  end

  assign adv_en = ctl.load | ctl.step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      mpl_q  <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      if (adv_en) begin
        cnt_q <= cnt_d;
        mpl_q <= mpl_d;
      end
    end
  end

  assign ctl_o  = ctl;
  assign idx_o  = cnt_q;
  assign busy_o = busy_q;
  assign done_o = done_q;

endmodule

// File: rtl/smul_ppgen.sv
module smul_ppgen #(
  parameter int W  = 8,
  parameter int IW = 3,
  localparam int PW = 2 * W
) (
  input  logic [W-1:0]  mcand_i,
  input  logic [IW-1:0] idx_i,
  input  logic          sel_i,
  input  logic          last_i,
  output logic [PW-1:0] term_o
);

  logic [PW-1:0] sext;
  logic [PW-1:0] shifted [W];
  logic [PW-1:0] mag;

  assign sext = {{W{mcand_i[W-1]}}, mcand_i};

  for (genvar g = 0; g < W; g++) begin : g_shift
    assign shifted[g] = sext << g;
  end

  always_comb begin
    mag = '0;
    for (int k = 0; k < W; k++) begin
      if (idx_i == IW'(k)) mag = shifted[k];
    end
  end

  // The sign bit of the multiplier weighs -2^(W-1): negate on the last step.
  always_comb begin
    if (!sel_i)      term_o = '0;
    else if (last_i) term_o = ~mag + 1'b1;
    else             term_o = mag;
  end

endmodule

// File: rtl/smul_accum.sv
module smul_accum #(
  parameter int W = 8,
  localparam int PW = 2 * W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic          step_i,
  input  logic [W-1:0]  mcand_i,
  input  logic [PW-1:0] term_i,
  output logic [W-1:0]  mcand_o,
  output logic [PW-1:0] acc_o
);

  logic [W-1:0]  mcand_q;
  logic [PW-1:0] acc_q, acc_d;
  logic          acc_en;

  assign acc_en = load_i | step_i;

  always_comb begin
    if (load_i) acc_d = '0;
    else        acc_d = acc_q + term_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcand_q <= '0;
      acc_q   <= '0;
    end else begin
      if (load_i) mcand_q <= mcand_i;
      if (acc_en) acc_q   <= acc_d;
    end
  end

  assign mcand_o = mcand_q;
  assign acc_o   = acc_q;

endmodule

// File: rtl/seq_signed_mul.sv
module seq_signed_mul
  import smul_pkg::*;
#(
  parameter int W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [W-1:0]     mcand_i,
  input  logic [W-1:0]     mplier_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [2*W-1:0]   product_o
);

  localparam int IW = (W > 1) ? $clog2(W) : 1;
  localparam int PW = 2 * W;

  smul_ctl_t     ctl;
  logic [IW-1:0] idx;
  logic [W-1:0]  mcand_q;
  logic [PW-1:0] term;

  smul_ctrl #(.W(W), .IW(IW)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .mplier_i (mplier_i),
    .ctl_o    (ctl),
    .idx_o    (idx),
    .busy_o   (busy_o),
    .done_o   (done_o)
  );

  smul_ppgen #(.W(W), .IW(IW)) u_ppgen (
    .mcand_i (mcand_q),
    .idx_i   (idx),
    .sel_i   (ctl.sel),
    .last_i  (ctl.last),
    .term_o  (term)
  );

  smul_accum #(.W(W)) u_accum (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (ctl.load),
    .step_i  (ctl.step),
    .mcand_i (mcand_i),
    .term_i  (term),
    .mcand_o (mcand_q),
    .acc_o   (product_o)
  );

endmodule

// File: rtl/smul_chk.sv
module smul_chk #(
  parameter int W = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start_i,
  input logic           busy_o,
  input logic           done_o,
  input logic [2*W-1:0] product_o
);

  localparam int CW = $clog2(W + 1) + 1;

  logic [CW-1:0] cyc_q;

  // Cycles spent busy since the last accepted start.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cyc_q <= '0;
    else if (!busy_o && start_i) cyc_q <= '0;
    else if (busy_o)             cyc_q <= cyc_q + 1'b1;
  end

  a_r3_latency: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (cyc_q == CW'(W)));

  a_r3_busy_drop: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r2_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i) |=> (busy_o && !done_o));

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> $stable(product_o));

endmodule

bind seq_signed_mul smul_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .product_o (product_o)
);

// File: tb/sim_seq_signed_mul.sv
module sim_seq_signed_mul;

  localparam int W  = 8;
  localparam int PW = 2 * W;

  logic          clk;
  logic          rst_n;
  logic          start_i;
  logic [W-1:0]  mcand_i;
  logic [W-1:0]  mplier_i;
  logic          busy_o;
  logic          done_o;
  logic [PW-1:0] product_o;

  int n_chk;
  int n_bad;
  int seed;

  seq_signed_mul #(.W(W)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .mcand_i   (mcand_i),
    .mplier_i  (mplier_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .product_o (product_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [PW-1:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b);
    int ia;
    int ib;
    int ip;
    ia = int'($signed(a));
    ib = int'($signed(b));
    ip = ia * ib;
    return PW'(ip);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  // One full operation; inject=1 pulses start_i while busy (R8).
  task automatic do_mul(input logic [W-1:0] a, input logic [W-1:0] b,
                        input bit inject, input string req);
    logic [PW-1:0] exp;
    logic [PW-1:0] held;
    int k;
    exp = ref_mul(a, b);
    @(negedge clk);
    start_i  = 1'b1;
    mcand_i  = a;
    mplier_i = b;
    @(negedge clk);
    start_i  = 1'b0;
    mcand_i  = W'($urandom());
    mplier_i = W'($urandom());
    chk(busy_o == 1'b1, "R2", "busy after accept", 64'(busy_o), 64'd1);
    k = 0;
    while (!done_o && k < W + 3) begin
      @(negedge clk);
      k++;
      if (inject && k == 2) begin
        start_i  = 1'b1;
        mcand_i  = ~a;
        mplier_i = ~b;
      end
      if (inject && k == 3) start_i = 1'b0;
    end
    chk(k == W, "R3", "done latency", 64'(k), 64'(W));
    chk(busy_o == 1'b0, "R3", "busy low with done", 64'(busy_o), 64'd0);
    chk(product_o == exp, req, "product", 64'(product_o), 64'(exp));
    held = product_o;
    @(negedge clk);
    chk(done_o == 1'b0, "R10", "done single cycle", 64'(done_o), 64'd0);
    chk(product_o == held, "R9", "product held", 64'(product_o), 64'(held));
    chk(busy_o == 1'b0, "R8", "no restart from ignored start", 64'(busy_o), 64'd0);
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    n_chk    = 0;
    n_bad    = 0;
    seed     = 32'h5EED_0042;
    void'($urandom(seed));
    rst_n    = 1'b0;
    start_i  = 1'b0;
    mcand_i  = '0;
    mplier_i = '0;
    repeat (3) @(negedge clk);
    chk(busy_o == 1'b0, "R1", "busy in reset", 64'(busy_o), 64'd0);
    chk(done_o == 1'b0, "R1", "done in reset", 64'(done_o), 64'd0);
    chk(product_o == '0, "R1", "product in reset", 64'(product_o), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy_o == 1'b0 && done_o == 1'b0, "R1", "idle after reset",
        64'({busy_o, done_o}), 64'd0);

    // R5: negative multipliers, final step subtracts
    do_mul(8'hFA, 8'hFB, 1'b0, "R5");   // -6 * -5 = 0x001E
    chk(product_o == 16'h001E, "R5", "(-6)x(-5)", 64'(product_o), 64'h1E);
    do_mul(8'h07, 8'hFD, 1'b0, "R5");   // 7 * -3 = 0xFFEB
    chk(product_o == 16'hFFEB, "R5", "7x(-3)", 64'(product_o), 64'hFFEB);
    do_mul(8'hFF, 8'hFF, 1'b0, "R5");   // -1 * -1
    // R4: mixed signs with positive multiplier
    do_mul(8'hFA, 8'h05, 1'b0, "R4");   // -6 * 5 = 0xFFE2
    chk(product_o == 16'hFFE2, "R4", "(-6)x5", 64'(product_o), 64'hFFE2);
    do_mul(8'h7F, 8'h7F, 1'b0, "R4");
    do_mul(8'h7F, 8'h80, 1'b0, "R4");
    // R6: zero operands
    do_mul(8'h00, 8'h80, 1'b0, "R6");
    do_mul(8'h93, 8'h00, 1'b0, "R6");
    // R7: most negative squared
    do_mul(8'h80, 8'h80, 1'b0, "R7");
    chk(product_o == 16'h4000, "R7", "min x min", 64'(product_o), 64'h4000);
    // R8: start while busy is ignored
    do_mul(8'h35, 8'hC9, 1'b1, "R8");
    do_mul(8'h80, 8'h81, 1'b1, "R8");
    // R9: idle cycles keep the result
    begin
      logic [PW-1:0] keep;
      keep = product_o;
      repeat (5) @(negedge clk);
      chk(product_o == keep, "R9", "idle hold", 64'(product_o), 64'(keep));
    end
    // R4: random operands, some with mid-run start pulses
    for (int i = 0; i < 60; i++) begin
      logic [W-1:0] ra;
      logic [W-1:0] rb;
      ra = W'($urandom());
      rb = W'($urandom());
      do_mul(ra, rb, (i % 4) == 3, "R4");
    end
    summary();
  end

endmodule